// File: doc/BRIEF.md
# Host Model Auto-Detector

This block watches the write cycles of a 16-bit-address host bus and works out which of three host variants it is attached to. Each write yields a 32-bit signature: the address fills the upper half, the low ten bits of the captured data/control word fill the bottom, and the six bits between them are zero. Three fixed signatures are known, one per variant. The first write whose signature matches one of them fixes the detected model. That model then holds until reset.

The detected model comes out as a two-bit code. Two enable flags are decoded from it: an extended enable and a further-extended enable. A neighbouring switch-shadow block uses these flags to decide which register groups it tracks. A write that matches nothing leaves the model undecided and clears the captured-signature register.

A static preset input can force a model instead of detecting one. While it is non-zero, the outputs follow the preset and detection stays idle. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block starts acting on the bus two clock edges after reset is released.

Top module: `host_model_detect`

## Requirements
- R1: After reset with preset 0, `model_o` is 0 (undecided), both enables are 0 and `first_sig` is 0.
- R2: A write of signature 0xC0330100 while undecided sets `model_o` to 3 (advanced model), `xext_en` to 1 and `ext_en` to 0, visible one clock edge later.
- R3: A write of signature 0x01F901FB while undecided sets `model_o` to 1 (base model) with both enables at 0.
- R4: A write of signature 0x01F5018B while undecided sets `model_o` to 2 (middle model), `ext_en` to 1 and `xext_en` to 0. The two enables are never both 1.
- R5: A write whose signature matches none of the three while undecided leaves `model_o` at 0 and sets `first_sig` to 0.
- R6: A matching write loads its signature into `first_sig`. Once `model_o` is non-zero, no later write changes `model_o`, the enables or `first_sig` until reset.
- R7: Cycles with `wr_valid` low change nothing.
- R8: The signature is {bus_addr[15:0], 6'b0, bus_word[9:0]}. Bits 15:10 of `bus_word` have no effect.
- R9: A non-zero `preset_model` drives `model_o` to that code, with enables decoded as in R2 to R4. Writes then change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_model | input | 2 | Forced model code; 0 selects auto-detection |
| wr_valid | input | 1 | A bus write cycle is presented this clock |
| bus_addr | input | 16 | Write address |
| bus_word | input | 16 | Captured data/control word |
| model_o | output | 2 | Model: 0 undecided, 1 base, 2 middle, 3 advanced |
| ext_en | output | 1 | Extended register group enable (middle model) |
| xext_en | output | 1 | Further-extended register group enable (advanced model) |
| first_sig | output | 32 | Captured signature of the deciding write, or 0 |

## Verification
A corrupted model register shows up on `model_o` and the enables one edge after the write that caused it. A missed match leaves `model_o` at 0 after a known signature. A match that is not sticky shows up when a later write changes `first_sig` or the model code. Stray high word bits or idle cycles that alter state are caught on the very next sample. Random traffic is mixed with injected signatures, so every model and every preset is exercised across many reset episodes.

// File: rtl/hmd_pkg.sv
package hmd_pkg;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 16;
  localparam int KEEP_W = 10;
  localparam int SIG_W  = 32;
  localparam int NUM_SIG = 3;

  typedef enum logic [1:0] {
    MDL_AUTO = 2'd0,
    MDL_BASE = 2'd1,
    MDL_MID  = 2'd2,
    MDL_ADV  = 2'd3
  } model_e;

  localparam logic [SIG_W-1:0] SIG_ADV  = 32'hC033_0100;
  localparam logic [SIG_W-1:0] SIG_BASE = 32'h01F9_01FB;
  localparam logic [SIG_W-1:0] SIG_MID  = 32'h01F5_018B;

  localparam logic [SIG_W-1:0] SIG_TAB [NUM_SIG] = '{SIG_ADV, SIG_BASE, SIG_MID};
  localparam model_e           MDL_TAB [NUM_SIG] = '{MDL_ADV, MDL_BASE, MDL_MID};

  function automatic logic [1:0] model_enables(model_e m);
    // bit 1: further-extended, bit 0: extended
    case (m)
      MDL_ADV: return 2'b10;
      MDL_MID: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/hmd_rst_sync.sv
module hmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/hmd_sig_form.sv
module hmd_sig_form
  import hmd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int WW = WORD_W,
  parameter int KW = KEEP_W,
  parameter int SW = SIG_W
) (
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] word,
  output logic [SW-1:0] sig
);
  localparam int PAD_W = SW - AW - KW;
  assign sig = {addr, {PAD_W{1'b0}}, word[KW-1:0]};
endmodule

// File: rtl/hmd_sig_match.sv
module hmd_sig_match
  import hmd_pkg::*;
#(
  parameter int N  = NUM_SIG,
  parameter int SW = SIG_W
) (
  input  logic [SW-1:0] sig,
  output logic          hit,
  output model_e        hit_model
);
  logic [N-1:0] hit_vec;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = (sig == SIG_TAB[i]);
  end

  always_comb begin
    hit_model = MDL_AUTO;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_model = MDL_TAB[i];
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/host_model_detect.sv
module host_model_detect
  import hmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        preset_model,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_word,
  output logic [1:0]        model_o,
  output logic              ext_en,
  output logic              xext_en,
  output logic [SIG_W-1:0]  first_sig
);
  logic             rst_sn;
  logic [SIG_W-1:0] sig;
  logic             hit;
  model_e           hit_model;
  model_e           model_q, model_d, model_eff;
  logic [SIG_W-1:0] sig_q, sig_d;
  logic             det_en;
  logic [1:0]       ens;

  hmd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  hmd_sig_form u_form (
    .addr (bus_addr),
    .word (bus_word),
    .sig  (sig)
  );

  hmd_sig_match u_match (
    .sig       (sig),
    .hit       (hit),
    .hit_model (hit_model)
  );

  assign model_eff = (model_e'(preset_model) != MDL_AUTO) ? model_e'(preset_model) : model_q;
  assign det_en    = wr_valid && (model_eff == MDL_AUTO);

  always_comb begin
    model_d = model_q;
    sig_d   = sig_q;
    if (det_en) begin
      if (hit) begin
        model_d = hit_model;
        sig_d   = sig;
      end else begin
        sig_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      model_q <= MDL_AUTO;
      sig_q   <= '0;
    end else if (det_en) begin
      model_q <= model_d;
      sig_q   <= sig_d;
    end
  end

  assign ens       = model_enables(model_eff);
  assign model_o   = model_eff;
  assign ext_en    = ens[0];
  assign xext_en   = ens[1];
  assign first_sig = sig_q;
endmodule

// File: rtl/hmd_checker.sv
module hmd_checker
  import hmd_pkg::*;
(
  input logic              clk,
  input logic              rst_sn,
  input logic [1:0]        preset_model,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_word,
  input logic [1:0]        model_o,
  input logic              ext_en,
  input logic              xext_en,
  input logic [SIG_W-1:0]  first_sig
);
  logic [SIG_W-1:0] csig;
  logic             auto_wr;
  assign csig    = {bus_addr, 6'b0, bus_word[9:0]};
  assign auto_wr = wr_valid && (model_o == 2'd0) && (preset_model == 2'd0);

  assert_adv_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (auto_wr && csig == 32'hC0330100) |=> (model_o == 2'd3 && xext_en && !ext_en));

  assert_base_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (auto_wr && csig == 32'h01F901FB) |=> (model_o == 2'd1 && !xext_en && !ext_en));

  assert_mid_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (auto_wr && csig == 32'h01F5018B) |=> (model_o == 2'd2 && ext_en && !xext_en));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    !(ext_en && xext_en));

  assert_nomatch_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (auto_wr && csig != 32'hC0330100 && csig != 32'h01F901FB && csig != 32'h01F5018B)
    |=> (model_o == 2'd0 && first_sig == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (model_o != 2'd0 && $stable(preset_model)) |=> ($stable(model_o) && $stable(first_sig)));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr_valid && $stable(preset_model)) |=> ($stable(model_o) && $stable(first_sig)));
endmodule

bind host_model_detect hmd_checker u_chk (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .preset_model (preset_model),
  .wr_valid     (wr_valid),
  .bus_addr     (bus_addr),
  .bus_word     (bus_word),
  .model_o      (model_o),
  .ext_en       (ext_en),
  .xext_en      (xext_en),
  .first_sig    (first_sig)
);

// File: tb/sim_host_model_detect.sv
`timescale 1ns/1ps
module sim_host_model_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  preset_model;
  logic        wr_valid;
  logic [15:0] bus_addr;
  logic [15:0] bus_word;
  logic [1:0]  model_o;
  logic        ext_en, xext_en;
  logic [31:0] first_sig;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0]  exp_model_q;
  logic [31:0] exp_sig_q;

  always #10 clk = ~clk;

  host_model_detect u0 (
    .clk(clk), .rst_n(rst_n), .preset_model(preset_model),
    .wr_valid(wr_valid), .bus_addr(bus_addr), .bus_word(bus_word),
    .model_o(model_o), .ext_en(ext_en), .xext_en(xext_en), .first_sig(first_sig)
  );

  function automatic logic [1:0] sig_model(logic [31:0] s);
    if (s == 32'hC0330100) return 2'd3;
    if (s == 32'h01F901FB) return 2'd1;
    if (s == 32'h01F5018B) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [1:0] eff_model();
    return (preset_model != 2'd0) ? preset_model : exp_model_q;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [1:0] m;
    m = eff_model();
    chk({req, " model"}, {30'd0, model_o}, {30'd0, m});
    chk({req, " ext_en"}, {31'd0, ext_en}, {31'd0, m == 2'd2});
    chk({req, " xext_en"}, {31'd0, xext_en}, {31'd0, m == 2'd3});
    chk({req, " first_sig"}, first_sig, exp_sig_q);
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(input logic wr, input logic [15:0] a, input logic [15:0] w, input string req);
    logic [31:0] s;
    wr_valid = wr; bus_addr = a; bus_word = w;
    s = {a, 6'b0, w[9:0]};
    if (wr && eff_model() == 2'd0) begin
      if (sig_model(s) != 2'd0) begin
        exp_model_q = sig_model(s);
        exp_sig_q   = s;
      end else begin
        exp_sig_q   = 32'd0;
      end
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic do_reset(input logic [1:0] pre);
    rst_n = 1'b0; wr_valid = 1'b0; bus_addr = '0; bus_word = '0;
    preset_model = pre;
    exp_model_q = 2'd0; exp_sig_q = 32'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all(pre == 2'd0 ? "R1 reset" : "R9 preset reset");
  endtask

  function automatic logic [31:0] pick_sig(int k);
    case (k)
      0: return 32'hC0330100;
      1: return 32'h01F901FB;
      default: return 32'h01F5018B;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] s;
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    do_reset(2'd0);
    // R7 idle cycles with a matching pattern on the bus
    step(1'b0, 16'hC033, 16'h0100, "R7 idle");
    // R5 non-matching write clears first_sig
    step(1'b1, 16'h1234, 16'h0055, "R5 nomatch");
    // R8 upper word bits ignored: advanced signature with junk bits 15:10
    step(1'b1, 16'hC033, 16'hFD00, "R8 R2 adv");
    // R6 later writes ignored
    step(1'b1, 16'h01F9, 16'h01FB, "R6 sticky");
    step(1'b1, 16'h4444, 16'h0000, "R6 sticky nomatch");
    // R3 base
    do_reset(2'd0);
    step(1'b1, 16'h01F9, 16'h01FB, "R3 base");
    // R4 middle
    do_reset(2'd0);
    step(1'b1, 16'h2000, 16'h0001, "R5 nomatch");
    step(1'b1, 16'h01F5, 16'h7D8B, "R4 mid");
    // R9 presets
    for (int p = 1; p < 4; p++) begin
      do_reset(p[1:0]);
      step(1'b1, 16'h01F5, 16'h018B, "R9 preset write");
    end
    // random episodes
    for (int ep = 0; ep < 200; ep++) begin
      do_reset(($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0);
      for (int i = 0; i < 20; i++) begin
        logic wr;
        logic [15:0] a, w;
        wr = ($urandom % 4) != 0;
        a = 16'($urandom); w = 16'($urandom);
        if ($urandom % 8 == 0) begin
          s = pick_sig(int'($urandom % 3));
          a = s[31:16];
          w = {w[15:10], s[9:0]};
        end
        step(wr, a, w, "R2 R3 R4 R5 R6 R7 R8 R9 random");
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule